// File: doc/BRIEF.md
# Display Layer Pixel Buffer with Underflow Recovery

This block is the short pixel queue at the output end of one display layer pipe. Pixels arrive from a memory-fetch stream with valid/ready handshaking. Each beat carries an end-of-line flag and an end-of-frame flag. The display timing side asks for one pixel per clock while the raster is inside the layer's active window, and takes the oldest queued pixel when one is there.

Fetching for a frame is armed by a programmable start line. This lets memory reads begin well before the raster reaches the layer.

An underflow happens when the display asks for a pixel and the queue is empty. On underflow the block:
- shows a programmable background colour with the valid flag low;
- enters a drop mode in which it accepts and throws away every remaining fetched beat of the frame at full rate;
- leaves drop mode once the end-of-frame beat has been taken, so the next frame runs normally with no software action;
- latches a sticky interrupt status bit, which only an explicit clear removes.

A per-frame counter of dropped beats is provided for debug.

Top module: `lyr_pixbuf`

## Requirements
- R1: The queue holds DEPTH (default 16) pixels and returns them in arrival order. `in_ready` is low whenever the queue is full and the block is not in drop mode.
- R2: `in_ready` first rises in the clock after a cycle with `line_start` high and `cur_line` equal to `fetch_line`. A `line_start` on any other line does not arm it. Once the end-of-frame beat has been accepted, `in_ready` returns low until the next arming.
- R3: When `px_req` is high, the queue is not empty and the block is not dropping, the same cycle shows `out_valid`=1, the oldest pixel on `out_pix`, and its end-of-line flag on `out_eol`. That entry is then removed.
- R4: When `px_req` is high, the queue is empty and the block is not dropping, an underflow occurs. In that cycle `out_valid`=0 and `out_pix`=`bg_pix`. From the next clock the block is in drop mode, unless an end-of-frame beat was accepted in that same cycle.
- R5: In drop mode, `in_ready` is 1 and every accepted beat is discarded. Any pixel request gives `out_valid`=0 and `out_pix`=`bg_pix`.
- R6: Drop mode ends in the clock after the end-of-frame beat is accepted. After the next arming, pixels are queued and shown normally again.
- R7: `irq_sts` becomes 1 in the clock after an underflow. It stays 1 until a cycle with `sts_clr`=1 and no underflow, after which it is 0. If a clear and an underflow fall in the same cycle, the bit stays 1.
- R8: `drop_count` goes to 0 in the clock after `frame_start`. Otherwise it adds one for each discarded beat, including a beat taken in the underflow cycle itself, and it saturates at its maximum.
- R9: In a `frame_start` cycle, `in_ready` is low unless the block is dropping, and from the next clock the queue is empty. `frame_start` also disarms fetching, unless that same cycle arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse at the top of each display frame |
| line_start | input | 1 | One-cycle pulse at the start of each display line |
| cur_line | input | LINE_W | Current raster line number |
| fetch_line | input | LINE_W | Line on which fetching for the layer is armed |
| bg_pix | input | PIX_W | Background pixel shown when no pixel is available |
| sts_clr | input | 1 | Write strobe that clears the underflow status |
| in_valid | input | 1 | Fetch beat valid |
| in_ready | output | 1 | Fetch beat accepted when high together with `in_valid` |
| in_pix | input | PIX_W | Fetched pixel |
| in_eol | input | 1 | Fetched pixel ends a line |
| in_eof | input | 1 | Fetched pixel ends the frame |
| px_req | input | 1 | Display asks for a pixel this cycle |
| out_valid | output | 1 | `out_pix` holds a real queued pixel |
| out_pix | output | PIX_W | Pixel to the display, or background |
| out_eol | output | 1 | End-of-line flag of the shown pixel |
| irq_sts | output | 1 | Sticky underflow interrupt status |
| drop_count | output | CNT_W | Beats discarded since the last frame start |

## Verification
The assertions check on every clock that:
- the queue is never written when full or read when empty;
- a flush or frame start leaves it empty;
- an underflow always leads to drop mode and a set status bit;
- the status bit never falls without a clear;
- the fetch side is always ready while dropping;
- the drop counter is zero after a frame start.

Only the directed scenarios can show the rest: pixel order and values across a full queue, that arming depends on the exact line, the background value during underflow, clear-versus-underflow priority, the exact drop count over a discarded frame, and a clean restart on the following frame.

// File: rtl/lyr_pixbuf_pkg.sv
`timescale 1ns/1ps
package lyr_pixbuf_pkg;

  typedef enum logic {
    LYR_RUN  = 1'b0,
    LYR_DROP = 1'b1
  } lyr_mode_e;

  // Next drop/run state from the current one, an underflow event and an
  // accepted end-of-frame beat.
  function automatic lyr_mode_e mode_next(lyr_mode_e cur, logic uf, logic eof_acc);
    if (cur == LYR_RUN) return (uf && !eof_acc) ? LYR_DROP : LYR_RUN;
    return eof_acc ? LYR_RUN : LYR_DROP;
  endfunction

endpackage

// File: rtl/lyr_fifo.sv
`timescale 1ns/1ps
module lyr_fifo #(
  parameter int W     = 25,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;
  logic [AW:0]  fill;

  function automatic logic [AW:0] level(logic [AW:0] wp, logic [AW:0] rp);
    return wp - rp;
  endfunction

  assign fill    = level(wr_ptr, rd_ptr);
  assign empty   = (fill == '0);
  assign full    = (fill == (AW+1)'(DEPTH));
  assign rd_data = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  assert_no_underread_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/lyr_uf_ctrl.sv
`timescale 1ns/1ps
module lyr_uf_ctrl
  import lyr_pixbuf_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic [LINE_W-1:0] cur_line,
  input  logic [LINE_W-1:0] fetch_line,
  input  logic              in_fire,
  input  logic              in_eof,
  input  logic              px_req,
  input  logic              fifo_empty,
  input  logic              sts_clr,
  output logic              discard,
  output logic              armed,
  output logic              uf_evt,
  output logic              drop_evt,
  output logic              irq_sts,
  output logic [CNT_W-1:0]  drop_count
);
  lyr_mode_e mode;
  logic      eof_acc;
  logic      line_hit;

  function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  assign discard  = (mode == LYR_DROP);
  assign uf_evt   = px_req && fifo_empty && !discard;
  assign drop_evt = in_fire && (discard || uf_evt);
  assign eof_acc  = in_fire && in_eof;
  assign line_hit = line_start && (cur_line == fetch_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= LYR_RUN;
      armed      <= 1'b0;
      irq_sts    <= 1'b0;
      drop_count <= '0;
    end else begin
      mode <= mode_next(mode, uf_evt, eof_acc);

      if (frame_start)   armed <= line_hit;
      else if (eof_acc)  armed <= 1'b0;
      else if (line_hit) armed <= 1'b1;

      if (uf_evt)       irq_sts <= 1'b1;
      else if (sts_clr) irq_sts <= 1'b0;

      if (frame_start)   drop_count <= '0;
      else if (drop_evt) drop_count <= sat_inc(drop_count);
    end
  end

  assert_uf_enters_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_evt && !eof_acc) |=> discard);
  assert_uf_sets_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> irq_sts);
  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sts && !sts_clr) |=> irq_sts);
  assert_count_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (drop_count == '0));

endmodule

// File: rtl/lyr_pixbuf.sv
`timescale 1ns/1ps
module lyr_pixbuf #(
  parameter int PIX_W  = 24,
  parameter int DEPTH  = 16,
  parameter int LINE_W = 11,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic [LINE_W-1:0] cur_line,
  input  logic [LINE_W-1:0] fetch_line,
  input  logic [PIX_W-1:0]  bg_pix,
  input  logic              sts_clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic              in_eol,
  input  logic              in_eof,
  input  logic              px_req,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pix,
  output logic              out_eol,
  output logic              irq_sts,
  output logic [CNT_W-1:0]  drop_count
);
  localparam int EW = PIX_W + 1;

  logic          discard, armed, uf_evt, drop_evt;
  logic          fifo_empty, fifo_full;
  logic          in_fire, wr_en, rd_en, flush;
  logic [EW-1:0] rd_entry;

  assign in_ready = discard || (armed && !fifo_full && !frame_start);
  assign in_fire  = in_valid && in_ready;
  assign wr_en    = in_fire && !discard && !uf_evt;
  assign rd_en    = px_req && !fifo_empty && !discard;
  assign flush    = frame_start || uf_evt;

  assign out_valid = rd_en;
  assign out_pix   = rd_en ? rd_entry[PIX_W-1:0] : bg_pix;
  assign out_eol   = rd_en && rd_entry[PIX_W];

  lyr_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .wr_en   (wr_en),
    .wr_data ({in_eol, in_pix}),
    .rd_en   (rd_en),
    .rd_data (rd_entry),
    .empty   (fifo_empty),
    .full    (fifo_full)
  );

  lyr_uf_ctrl #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_start  (line_start),
    .cur_line    (cur_line),
    .fetch_line  (fetch_line),
    .in_fire     (in_fire),
    .in_eof      (in_eof),
    .px_req      (px_req),
    .fifo_empty  (fifo_empty),
    .sts_clr     (sts_clr),
    .discard     (discard),
    .armed       (armed),
    .uf_evt      (uf_evt),
    .drop_evt    (drop_evt),
    .irq_sts     (irq_sts),
    .drop_count  (drop_count)
  );

  assert_drop_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> in_ready);
  assert_drop_no_show_R5: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> !out_valid);

endmodule

// File: tb/lyr_pixbuf_test.sv
`timescale 1ns/1ps
module lyr_pixbuf_test;
  localparam int PIX_W = 24, LINE_W = 11, CNT_W = 16;
  localparam logic [PIX_W-1:0] BG = 24'hABCDEF;

  logic clk = 0, rst_n = 0;
  logic frame_start = 0, line_start = 0, sts_clr = 0;
  logic [LINE_W-1:0] cur_line = '0, fetch_line = 11'd3;
  logic in_valid = 0, in_eol = 0, in_eof = 0, px_req = 0;
  logic [PIX_W-1:0] in_pix = '0;
  logic in_ready, out_valid, out_eol, irq_sts;
  logic [PIX_W-1:0] out_pix;
  logic [CNT_W-1:0] drop_count;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  lyr_pixbuf uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .cur_line(cur_line), .fetch_line(fetch_line), .bg_pix(BG), .sts_clr(sts_clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_eol(in_eol),
    .in_eof(in_eof), .px_req(px_req), .out_valid(out_valid), .out_pix(out_pix),
    .out_eol(out_eol), .irq_sts(irq_sts), .drop_count(drop_count)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic arm(logic [LINE_W-1:0] ln);
    line_start = 1; cur_line = ln; step(); line_start = 0;
  endtask

  task automatic push(logic [PIX_W-1:0] p, logic eol, logic eof);
    in_valid = 1; in_pix = p; in_eol = eol; in_eof = eof; step();
    in_valid = 0; in_eol = 0; in_eof = 0;
  endtask

  task automatic pulse_frame();
    frame_start = 1; step(); frame_start = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (3) step(); rst_n = 1; step(); #1;
    check("R2 reset in_ready", in_ready, 0);
    check("R7 reset irq", irq_sts, 0);
    check("R8 reset count", drop_count, 0);
    check("R3 reset out_valid", out_valid, 0);
  endtask

  task automatic t_arm();
    arm(11'd2); #1;
    check("R2 wrong line no arm", in_ready, 0);
    arm(11'd3); #1;
    check("R2 armed on fetch line", in_ready, 1);
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < 16; i++) push(PIX_W'(100 + i), i == 7, 0);
    #1 check("R1 full blocks ready", in_ready, 0);
    px_req = 1;
    for (int i = 0; i < 16; i++) begin
      #1;
      check("R3 valid", out_valid, 1);
      check("R1 R3 order", out_pix, 100 + i);
      check("R3 eol", out_eol, i == 7);
      step();
    end
    px_req = 0;
  endtask

  task automatic t_underflow();
    px_req = 1; #1;
    check("R4 uf valid low", out_valid, 0);
    check("R4 uf background", out_pix, BG);
    step(); px_req = 0; #1;
    check("R7 irq set", irq_sts, 1);
    check("R5 ready in drop", in_ready, 1);
    for (int i = 0; i < 5; i++) push(PIX_W'(500 + i), 0, 0);
    px_req = 1; #1;
    check("R5 drop no show", out_valid, 0);
    check("R5 drop background", out_pix, BG);
    step(); px_req = 0;
    push(PIX_W'(505), 0, 1); #1;
    check("R8 drop count", drop_count, 6);
    check("R6 drop ends, disarmed", in_ready, 0);
  endtask

  task automatic t_irq();
    sts_clr = 1; step(); sts_clr = 0; #1;
    check("R7 clear", irq_sts, 0);
    sts_clr = 1; px_req = 1; step(); sts_clr = 0; px_req = 0; #1;
    check("R7 set wins over clear", irq_sts, 1);
    push(PIX_W'(600), 0, 1); #1;
    check("R8 count accumulates", drop_count, 7);
  endtask

  task automatic t_frame_flush();
    pulse_frame(); #1;
    check("R8 frame clears count", drop_count, 0);
    arm(11'd3);
    for (int i = 0; i < 3; i++) push(PIX_W'(200 + i), 0, 0);
    frame_start = 1; #1;
    check("R9 not ready at frame start", in_ready, 0);
    step(); frame_start = 0;
    px_req = 1; #1;
    check("R9 flushed queue", out_valid, 0);
    step(); px_req = 0;
    push(PIX_W'(203), 0, 1); #1;
    check("R8 count after flush uf", drop_count, 1);
  endtask

  task automatic t_resume();
    pulse_frame();
    arm(11'd3); #1;
    check("R6 re-armed next frame", in_ready, 1);
    push(PIX_W'(300), 0, 0);
    push(PIX_W'(301), 1, 1); #1;
    check("R2 disarm after eof", in_ready, 0);
    px_req = 1; #1;
    check("R6 resume valid", out_valid, 1);
    check("R6 resume pix0", out_pix, 300);
    step(); #1;
    check("R6 resume pix1", out_pix, 301);
    check("R3 resume eol", out_eol, 1);
    step(); px_req = 0; #1;
    check("R7 still sticky", irq_sts, 1);
    check("R8 no drops", drop_count, 0);
  endtask

  initial begin
    t_reset();
    t_arm();
    t_fill_drain();
    t_underflow();
    t_irq();
    t_frame_flush();
    t_resume();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule